// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between an instruction cache data array and the fetch/decode stage. When fetch asks for an instruction, the block first looks in a small buffer. The buffer holds one aligned group of four consecutive 32-bit instructions, a tag and a valid flag. If the group is not held, the block issues one read on the array port. The array returns the whole group one cycle later. That group is handed straight to fetch and kept in the buffer. Later requests that stay inside the group are answered from the buffer, up to two instructions per cycle, without touching the array. A sequential stream therefore costs one array read per four instructions.

The block also watches the line-fill port. A word being filled that matches the word fetch is asking for is forwarded at once as a single instruction. A fill that lands anywhere in the cache line containing the buffered group, or the group whose read is in flight, drops that copy so stale words are never issued. A flush input empties the buffer. All addresses are word addresses: the two lowest bits of a fetch address pick the word within its group, and the bits above them form the group tag.

Top module: `fetch_line_buf`

## Requirements
- R1: A request whose group is neither buffered nor arriving from the array, and that is not flushed or forwarded, drives `arr_rd_en_o` high with `arr_rd_addr_o` equal to the fetch address without its two low bits. `fetch_valid_o` stays low in that cycle.
- R2: In the cycle after an array read, the returned group (word k in bits [32k+31:32k]) is served to a request in that group, and it becomes the buffer contents.
- R3: A request that hits the valid buffered group issues no array read and returns the buffered words. Sixteen sequential instructions from a cold start cost exactly four array reads.
- R4: On a buffer or array hit, an even word index (address bit 0 clear) issues two instructions, word index and index+1, with `fetch_cnt_o` = 2. An odd index issues one, with `fetch_cnt_o` = 1 and `fetch_instr1_o` = 0.
- R5: When `fill_valid_i` is high and `fill_addr_i` equals the fetch address, the fill word is issued as `fetch_instr0_o` with count 1 and no array read. This takes priority over the buffer.
- R6: `flush_i` blocks issue and array read in its cycle and empties the buffer, so the next request misses unless forwarded.
- R7: A fill whose address lies in the same 8-word line as the buffered group, or the group being read, suppresses a buffer hit that cycle and invalidates that group.
- R8: After reset the buffer is empty: with no request nothing is issued or read, and the first request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req_i | input | 1 | Fetch wants an instruction this cycle |
| fetch_addr_i | input | 30 | Word address of requested instruction |
| flush_i | input | 1 | Branch/invalidate: drop buffered group |
| fetch_valid_o | output | 1 | Instructions issued this cycle |
| fetch_cnt_o | output | 2 | Number issued (1 or 2) |
| fetch_instr0_o | output | 32 | Instruction at the requested address |
| fetch_instr1_o | output | 32 | Following instruction when count is 2, else 0 |
| arr_rd_en_o | output | 1 | Array group read request |
| arr_rd_addr_o | output | 28 | Group address to read |
| arr_rd_data_i | input | 128 | Group returned one cycle after the read |
| fill_valid_i | input | 1 | A line-fill word is written this cycle |
| fill_addr_i | input | 30 | Word address of the fill word |
| fill_data_i | input | 32 | Fill word |

## Verification
The two functions that collide in one cycle are the buffer hit and the fill path. A fill can hit the exact word requested, which must forward. It can also land elsewhere in the buffered or in-flight line, which must kill the hit and force a new read. The bench aims fills at the current fetch word half the time and elsewhere in a small address region otherwise. This lands fills during array returns as well as buffer hits. A bench model of the buffer, built from the requirements, decides each cycle which outcome must win and compares issue, count, words and read address.

// File: rtl/flb_pkg.sv
package flb_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_FWD  = 2'd1,
        SRC_BUF  = 2'd2,
        SRC_MISS = 2'd3
    } fetch_src_e;
endpackage

// File: rtl/lb_store.sv
module lb_store #(
    parameter int IW = 32,
    parameter int GW = 4,
    parameter int TW = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             kill_i,
    input  logic             issue_i,
    input  logic [TW-1:0]    issue_tag_i,
    input  logic             issue_stale_i,
    input  logic [GW*IW-1:0] arr_data_i,
    output logic             eff_valid_o,
    output logic [TW-1:0]    eff_tag_o,
    output logic [GW*IW-1:0] eff_data_o
);
    typedef struct packed {
        logic             buf_v;
        logic [TW-1:0]    buf_tag;
        logic [GW*IW-1:0] buf_data;
        logic             pend;
        logic             pend_stale;
        logic [TW-1:0]    pend_tag;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        eff_valid_o = st_q.pend ? !st_q.pend_stale : st_q.buf_v;
        eff_tag_o   = st_q.pend ? st_q.pend_tag : st_q.buf_tag;
        eff_data_o  = st_q.pend ? arr_data_i : st_q.buf_data;
    end

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            st_d.buf_tag  = st_q.pend_tag;
            st_d.buf_data = arr_data_i;
            st_d.buf_v    = !st_q.pend_stale;
        end
        if (kill_i || flush_i) begin
            st_d.buf_v = 1'b0;
        end
        st_d.pend       = issue_i && !flush_i;
        st_d.pend_stale = issue_stale_i;
        st_d.pend_tag   = issue_tag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lb_pick.sv
module lb_pick #(
    parameter int IW  = 32,
    parameter int GW  = 4,
    parameter int IXW = 2
) (
    input  logic [GW*IW-1:0] grp_i,
    input  logic [IXW-1:0]   idx_i,
    output logic [IW-1:0]    w0_o,
    output logic [IW-1:0]    w1_o,
    output logic             pair_o
);
    logic [IW-1:0] next_w;

    always_comb begin
        w0_o   = '0;
        next_w = '0;
        for (int k = 0; k < GW; k++) begin
            if (IXW'(k) == idx_i) begin
                w0_o = grp_i[k*IW +: IW];
            end
            if (k > 0 && IXW'(k - 1) == idx_i) begin
                next_w = grp_i[k*IW +: IW];
            end
        end
        pair_o = !idx_i[0];
        w1_o   = pair_o ? next_w : '0;
    end
endmodule

// File: rtl/fetch_line_buf.sv
module fetch_line_buf
    import flb_pkg::*;
#(
    parameter int AW         = 30,
    parameter int IW         = 32,
    parameter int GW         = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fetch_req_i,
    input  logic [AW-1:0]            fetch_addr_i,
    input  logic                     flush_i,
    output logic                     fetch_valid_o,
    output logic [1:0]               fetch_cnt_o,
    output logic [IW-1:0]            fetch_instr0_o,
    output logic [IW-1:0]            fetch_instr1_o,
    output logic                     arr_rd_en_o,
    output logic [AW-$clog2(GW)-1:0] arr_rd_addr_o,
    input  logic [GW*IW-1:0]         arr_rd_data_i,
    input  logic                     fill_valid_i,
    input  logic [AW-1:0]            fill_addr_i,
    input  logic [IW-1:0]            fill_data_i
);
    localparam int IXW = $clog2(GW);
    localparam int TW  = AW - IXW;
    localparam int LNW = $clog2(LINE_WORDS);
    localparam int SH  = LNW - IXW;
    localparam int LTW = AW - LNW;

    logic             eff_valid;
    logic [TW-1:0]    eff_tag;
    logic [GW*IW-1:0] eff_data;
    logic [IW-1:0]    pick_w0, pick_w1;
    logic             pick_pair;

    logic [TW-1:0]    req_tag;
    logic [IXW-1:0]   req_idx;
    logic [LTW-1:0]   fill_line;
    logic             kill, issue_stale, fwd, hit, issue;
    fetch_src_e       src;

    assign req_tag   = fetch_addr_i[AW-1:IXW];
    assign req_idx   = fetch_addr_i[IXW-1:0];
    assign fill_line = fill_addr_i[AW-1:LNW];

    always_comb begin
        kill        = fill_valid_i && (fill_line == eff_tag[TW-1:SH]);
        issue_stale = fill_valid_i && (fill_line == fetch_addr_i[AW-1:LNW]);
        fwd         = fetch_req_i && fill_valid_i && (fill_addr_i == fetch_addr_i);
        hit         = fetch_req_i && eff_valid && !kill && (eff_tag == req_tag);
        if (flush_i || !fetch_req_i) begin
            src = SRC_IDLE;
        end else if (fwd) begin
            src = SRC_FWD;
        end else if (hit) begin
            src = SRC_BUF;
        end else begin
            src = SRC_MISS;
        end
        issue = (src == SRC_MISS);
    end

    lb_store #(.IW(IW), .GW(GW), .TW(TW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .kill_i       (kill),
        .issue_i      (issue),
        .issue_tag_i  (req_tag),
        .issue_stale_i(issue_stale),
        .arr_data_i   (arr_rd_data_i),
        .eff_valid_o  (eff_valid),
        .eff_tag_o    (eff_tag),
        .eff_data_o   (eff_data)
    );

    lb_pick #(.IW(IW), .GW(GW), .IXW(IXW)) u_pick (
        .grp_i (eff_data),
        .idx_i (req_idx),
        .w0_o  (pick_w0),
        .w1_o  (pick_w1),
        .pair_o(pick_pair)
    );

    always_comb begin
        fetch_valid_o  = 1'b0;
        fetch_cnt_o    = 2'd0;
        fetch_instr0_o = '0;
        fetch_instr1_o = '0;
        arr_rd_en_o    = issue;
        arr_rd_addr_o  = req_tag;
        unique case (src)
            SRC_FWD: begin
                fetch_valid_o  = 1'b1;
                fetch_cnt_o    = 2'd1;
                fetch_instr0_o = fill_data_i;
            end
            SRC_BUF: begin
                fetch_valid_o  = 1'b1;
                fetch_cnt_o    = pick_pair ? 2'd2 : 2'd1;
                fetch_instr0_o = pick_w0;
                fetch_instr1_o = pick_w1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flb_chk.sv
module flb_chk #(
    parameter int AW = 30,
    parameter int IW = 32,
    parameter int GW = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fetch_req_i,
    input logic [AW-1:0]            fetch_addr_i,
    input logic                     flush_i,
    input logic                     fetch_valid_o,
    input logic [1:0]               fetch_cnt_o,
    input logic [IW-1:0]            fetch_instr0_o,
    input logic [IW-1:0]            fetch_instr1_o,
    input logic                     arr_rd_en_o,
    input logic [AW-$clog2(GW)-1:0] arr_rd_addr_o,
    input logic                     fill_valid_i,
    input logic [AW-1:0]            fill_addr_i,
    input logic [IW-1:0]            fill_data_i
);
    localparam int IXW = $clog2(GW);

    // R1
    miss_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en_o |-> (!fetch_valid_o && arr_rd_addr_o == fetch_addr_i[AW-1:IXW]));

    // R4
    pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && fetch_cnt_o == 2'd2) |-> !fetch_addr_i[0]);

    // R4
    single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && fetch_cnt_o == 2'd1) |-> (fetch_instr1_o == '0));

    // R5
    fill_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_i && !flush_i && fill_valid_i && fill_addr_i == fetch_addr_i)
        |-> (fetch_valid_o && fetch_cnt_o == 2'd1 && fetch_instr0_o == fill_data_i));

    // R6
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (!fetch_valid_o && !arr_rd_en_o));

    // R6
    flush_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!(fetch_req_i && !flush_i && !fill_valid_i) || arr_rd_en_o));
endmodule

bind fetch_line_buf flb_chk #(.AW(AW), .IW(IW), .GW(GW)) u_flb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .flush_i       (flush_i),
    .fetch_valid_o (fetch_valid_o),
    .fetch_cnt_o   (fetch_cnt_o),
    .fetch_instr0_o(fetch_instr0_o),
    .fetch_instr1_o(fetch_instr1_o),
    .arr_rd_en_o   (arr_rd_en_o),
    .arr_rd_addr_o (arr_rd_addr_o),
    .fill_valid_i  (fill_valid_i),
    .fill_addr_i   (fill_addr_i),
    .fill_data_i   (fill_data_i)
);

// File: tb/fetch_line_buf_test.sv
`timescale 1ns/1ps
module fetch_line_buf_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_req_i = 1'b0;
    logic [29:0]  fetch_addr_i = '0;
    logic         flush_i = 1'b0;
    logic         fetch_valid_o;
    logic [1:0]   fetch_cnt_o;
    logic [31:0]  fetch_instr0_o, fetch_instr1_o;
    logic         arr_rd_en_o;
    logic [27:0]  arr_rd_addr_o;
    logic [127:0] arr_rd_data_i = '0;
    logic         fill_valid_i = 1'b0;
    logic [29:0]  fill_addr_i = '0;
    logic [31:0]  fill_data_i = '0;

    fetch_line_buf uut (.*);

    always #4 clk = ~clk;

    int errs = 0, checks = 0, reads = 0;
    bit done = 1'b0;
    logic [31:0]  mem [64];
    logic         mb_v = 1'b0, mp = 1'b0, mp_stale = 1'b0;
    logic [27:0]  mb_tag = '0, mp_tag = '0;
    logic [127:0] mb_data = '0, mp_data = '0;
    logic         last_v = 1'b0;
    logic [1:0]   last_cnt = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] grp_of(input logic [29:0] a);
        logic [127:0] g;
        for (int k = 0; k < 4; k++) g[k*32 +: 32] = mem[{a[5:2], k[1:0]}];
        return g;
    endfunction

    task automatic step(input bit req, input logic [29:0] a, input bit fl,
                        input bit fv, input logic [29:0] fa, input logic [31:0] fd);
        logic         ev, kill, fwd, hit, rd, pair, nbv;
        logic [27:0]  et;
        logic [127:0] ed;
        logic [31:0]  e0, e1;
        string        tag;
        @(negedge clk);
        fetch_req_i = req; fetch_addr_i = a; flush_i = fl;
        fill_valid_i = fv; fill_addr_i = fa; fill_data_i = fd;
        arr_rd_data_i = mp ? mp_data : {$urandom, $urandom, $urandom, $urandom};
        #1;
        ev   = mp ? !mp_stale : mb_v;
        et   = mp ? mp_tag : mb_tag;
        ed   = mp ? mp_data : mb_data;
        kill = fv && (fa[29:3] == et[27:1]);
        fwd  = req && fv && (fa == a);
        hit  = req && ev && !kill && (et == a[29:2]);
        rd   = req && !fl && !fwd && !hit;
        pair = !a[0];
        e0   = ed[a[1:0]*32 +: 32];
        e1   = pair ? ed[(a[1:0]+2'd1)*32 +: 32] : 32'h0;
        if (arr_rd_en_o) reads++;
        tag  = fl ? "R6" : (ev && (et == a[29:2]) && kill) ? "R7" : "R1";
        chk(arr_rd_en_o == rd, tag, 64'(arr_rd_en_o), 64'(rd));
        if (rd) chk(arr_rd_addr_o == a[29:2], "R1", 64'(arr_rd_addr_o), 64'(a[29:2]));
        if (!req || fl || rd) begin
            chk(fetch_valid_o == 1'b0, fl ? "R6" : "R1", 64'(fetch_valid_o), 64'd0);
        end else if (fwd) begin
            chk(fetch_valid_o && fetch_cnt_o == 2'd1 && fetch_instr0_o == fd, "R5",
                {fetch_cnt_o, fetch_instr0_o}, {2'd1, fd});
        end else begin
            tag = mp ? "R2" : "R3";
            chk(fetch_valid_o, tag, 64'(fetch_valid_o), 64'd1);
            chk(fetch_cnt_o == (pair ? 2'd2 : 2'd1), "R4", 64'(fetch_cnt_o), pair ? 64'd2 : 64'd1);
            chk(fetch_instr0_o == e0 && fetch_instr1_o == e1, tag,
                {fetch_instr0_o, fetch_instr1_o}, {e0, e1});
        end
        last_v = fetch_valid_o; last_cnt = fetch_cnt_o;
        nbv = mb_v;
        if (mp) begin mb_tag = mp_tag; mb_data = mp_data; nbv = !mp_stale; end
        if (kill || fl) nbv = 1'b0;
        mb_v = nbv;
        mp = rd;
        if (rd) begin
            mp_tag = a[29:2]; mp_data = grp_of(a);
            mp_stale = fv && (fa[29:3] == a[29:3]);
        end
        if (fv) mem[fa[5:0]] = fd;
    endtask

    function automatic logic [29:0] mk(input bit hi, input logic [5:0] w);
        return {15'd0, hi, 8'd0, w};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [29:0] cur;
        int seq_reads, served;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 + i * 32'h0000_1011;
        repeat (3) begin
            @(negedge clk); #1;
            chk(!fetch_valid_o && !arr_rd_en_o, "R8", {fetch_valid_o, arr_rd_en_o}, 64'd0);
        end
        @(negedge clk); rst_n = 1'b1;
        // R8: first request after reset must miss
        step(1, mk(0, 6'd5), 0, 0, '0, '0);
        chk(arr_rd_en_o && !fetch_valid_o, "R8", {arr_rd_en_o, fetch_valid_o}, 64'h2);
        // R3: sixteen sequential instructions cost four reads
        step(0, '0, 1, 0, '0, '0);
        seq_reads = reads; served = 0; cur = mk(0, 6'd16);
        for (int i = 0; i < 40 && served < 16; i++) begin
            step(1, cur, 0, 0, '0, '0);
            if (last_v) begin served += last_cnt; cur = cur + 30'(last_cnt); end
        end
        chk(reads - seq_reads == 4, "R3", 64'(reads - seq_reads), 64'd4);
        // R4: odd word in a buffered group issues one
        step(1, mk(0, 6'd33), 0, 0, '0, '0);
        step(1, mk(0, 6'd35), 0, 0, '0, '0);
        chk(fetch_cnt_o == 2'd1 && fetch_instr1_o == 0, "R4", 64'(fetch_cnt_o), 64'd1);
        // R5: forwarded fill word beats a buffer hit
        step(1, mk(0, 6'd34), 0, 1, mk(0, 6'd34), 32'hFEED_0042);
        chk(fetch_instr0_o == 32'hFEED_0042, "R5", 64'(fetch_instr0_o), 64'hFEED_0042);
        // R7: fill elsewhere in the buffered line forces a new read
        step(1, mk(0, 6'd40), 0, 0, '0, '0);
        step(1, mk(0, 6'd40), 0, 0, '0, '0);
        step(0, '0, 0, 1, mk(0, 6'd45), 32'h0BAD_0045);
        step(1, mk(0, 6'd40), 0, 0, '0, '0);
        chk(arr_rd_en_o, "R7", 64'(arr_rd_en_o), 64'd1);
        // R6: flush then re-request misses
        step(1, mk(0, 6'd41), 0, 0, '0, '0);
        step(1, mk(0, 6'd41), 1, 0, '0, '0);
        step(1, mk(0, 6'd41), 0, 0, '0, '0);
        chk(arr_rd_en_o, "R6", 64'(arr_rd_en_o), 64'd1);
        // random mix
        cur = mk(0, 6'd0);
        for (int i = 0; i < 4000; i++) begin
            bit req, fl, fv;
            logic [29:0] fa;
            if (last_v) cur = mk(cur[14], cur[5:0] + 6'(last_cnt));
            if ($urandom % 100 < 8) cur = mk(1'($urandom), 6'($urandom));
            req = ($urandom % 10) != 0;
            fl  = ($urandom % 40) == 0;
            fv  = ($urandom % 6) == 0;
            fa  = ($urandom % 2) ? cur : mk(1'($urandom), 6'($urandom));
            step(req, cur, fl, fv, fa, $urandom);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule